// File: doc/BRIEF.md
# SCL Phase and Strobe Generator

This block turns the fast system clock into the slow serial clock level of a two-wire (I2C) bus master. A free-running phase counter counts system cycles through one bus period. The length of that period is the ratio of the system clock frequency to the bus clock frequency. The counter's position decides whether the serial clock is in its low half or its high half.

Besides the level, the block gives two single-cycle pulses placed in the middle of each half:

- The mid-low pulse is the step point for a bus controller's state machine. It is also where the data line may change.
- The mid-high pulse is the point at which the data line is sampled and at which start and stop edges are made.

Output-enable and open-drain handling are left to the surrounding controller.

A run input holds the generator at the start of a period while the bus is idle. When run rises, a fresh period begins from count zero. All outputs are registered, so the level and the pulses come straight from flops.

Top module: `scl_strobe_gen`

## Requirements
- R1: The period length in system cycles is DIV = SYS_HZ / BUS_HZ (integer division). While run stays high, successive mid-low pulses are exactly DIV cycles apart.
- R2: With phase count c running 0 to DIV-1, the level output is 0 for c < DIV/2 (floor) and 1 for the other counts.
- R3: The mid-low pulse is high for exactly the one cycle in which c equals floor(DIV/4), and only while the level is 0.
- R4: The mid-high pulse is high for exactly the one cycle in which c equals floor(DIV/2) + floor((DIV+1)/4), and only while the level is 1.
- R5: The two pulses are never high in the same cycle.
- R6: While rst_n is low, c is 0, the level is 0 and both pulses are 0. This applies at any time, including in the middle of a period.
- R7: After a clock edge that sees run low, c is 0, the level is 0 and neither pulse is high. After run returns high, counting resumes from c = 0, so the first mid-low pulse arrives floor(DIV/4) edges later.
- R8: Elaboration fails if DIV is below 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = generate bus periods, 0 = hold at count 0 |
| scl_lvl | output | 1 | Internal serial clock level (0 = low half) |
| stb_low | output | 1 | One-cycle pulse at the middle of the low half |
| stb_high | output | 1 | One-cycle pulse at the middle of the high half |

## Verification
The bench provokes a clash between run being dropped and a pulse that is due in the very next cycle. It lowers run at every phase offset of a period, on two configurations: one with an even ratio (10) and one with an odd ratio (7).

The bench's own phase model shows that the suppression wins. In the cycle after the drop, the level must read 0 and neither pulse may appear. The restart that follows must then place its pulses as if the period had just begun.

A reset applied while the generator is counting gets the same treatment.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // System cycles in one bus period.
  function automatic int unsigned f_div(input int unsigned sys_hz, input int unsigned bus_hz);
    return sys_hz / bus_hz;
  endfunction

  // Counts spent in the low half (the shorter half when the ratio is odd).
  function automatic int unsigned f_low_len(input int unsigned div);
    return div / 2;
  endfunction

  // Count at which the mid-low pulse fires.
  function automatic int unsigned f_lo_mid(input int unsigned div);
    return f_low_len(div) / 2;
  endfunction

  // Count at which the mid-high pulse fires.
  function automatic int unsigned f_hi_mid(input int unsigned div);
    return f_low_len(div) + (div - f_low_len(div)) / 2;
  endfunction

  // Width of a counter that holds 0 .. div-1.
  function automatic int unsigned f_cnt_w(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction

endpackage

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int unsigned DIV = 125,
  parameter int unsigned CW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R1: the count never runs past the last phase of a period.
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R1: at the end of a period the count returns to zero.
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |=> (cnt_q == '0));

  // R7: run low clears the count.
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/scl_phase_dec.sv
module scl_phase_dec
  import scl_gen_pkg::*;
#(
  parameter int unsigned DIV = 125,
  parameter int unsigned CW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_nxt,
  output logic          scl_q,
  output logic          stb_lo_q,
  output logic          stb_hi_q
);

  localparam logic [CW-1:0] HALF   = CW'(f_low_len(DIV));
  localparam logic [CW-1:0] LO_MID = CW'(f_lo_mid(DIV));
  localparam logic [CW-1:0] HI_MID = CW'(f_hi_mid(DIV));

  // Decode of the count the counter is about to load.
  // The outputs below therefore line up with the counter's register.
  logic hit_lo, hit_hi, in_high;
  assign in_high = (cnt_nxt >= HALF);
  assign hit_lo  = (cnt_nxt == LO_MID);
  assign hit_hi  = (cnt_nxt == HI_MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b0;
      stb_lo_q <= 1'b0;
      stb_hi_q <= 1'b0;
    end else begin
      scl_q    <= in_high;
      stb_lo_q <= hit_lo;
      stb_hi_q <= hit_hi;
    end
  end

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_lo_q && stb_hi_q));

  a_r3_lo_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lo_q |-> !scl_q);

  a_r4_hi_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    stb_hi_q |-> scl_q);

  a_r3_lo_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lo_q |=> !stb_lo_q);

  a_r4_hi_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_hi_q |=> !stb_hi_q);

endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned SYS_HZ = 50_000_000,
  parameter int unsigned BUS_HZ = 400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic scl_lvl,
  output logic stb_low,
  output logic stb_high
);

  localparam int unsigned DIV = f_div(SYS_HZ, BUS_HZ);
  localparam int unsigned CW  = f_cnt_w(DIV);

  // R8: a period shorter than four cycles cannot place both mid-points.
  generate
    if (DIV < 4) begin : g_bad_ratio
      $error("scl_strobe_gen: divide ratio %0d is below 4", DIV);
    end
  endgenerate

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          period_end;

  scl_phase_ctr #(.DIV(DIV), .CW(CW)) i_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (period_end)
  );

  scl_phase_dec #(.DIV(DIV), .CW(CW)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_nxt  (cnt_nxt),
    .scl_q    (scl_lvl),
    .stb_lo_q (stb_low),
    .stb_hi_q (stb_high)
  );

  // R7: an edge with run low leaves the bus in its low phase, with no pulse.
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_lvl && !stb_low && !stb_high));

  // R2: the level rises only when the count enters the high half.
  a_r2_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_lvl) |-> (cnt_q == CW'(f_low_len(DIV))));

  // R2: the level falls only at the start of a period.
  a_r2_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_lvl) |-> (cnt_q == '0));

endmodule

// File: tb/test_scl_strobe_gen.sv
module test_scl_strobe_gen;

  localparam int DA = 10;   // even ratio: 1000 / 100
  localparam int DB = 7;    // odd ratio:  700 / 100

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic scl_a, lo_a, hi_a, scl_b, lo_b, hi_b;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  scl_strobe_gen #(.SYS_HZ(1000), .BUS_HZ(100)) i_scl_strobe_gen (
    .clk(clk), .rst_n(rst_n), .run(run),
    .scl_lvl(scl_a), .stb_low(lo_a), .stb_high(hi_a));

  scl_strobe_gen #(.SYS_HZ(700), .BUS_HZ(100)) i_scl_strobe_gen_b (
    .clk(clk), .rst_n(rst_n), .run(run),
    .scl_lvl(scl_b), .stb_low(lo_b), .stb_high(hi_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected phase of each instance, taken from the requirement text.
  int ph_a = 0, ph_b = 0;
  bit run_seen = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a <= 0; ph_b <= 0; run_seen <= 1'b0;
    end else begin
      run_seen <= run;
      ph_a <= run ? (ph_a + 1) % DA : 0;
      ph_b <= run ? (ph_b + 1) % DB : 0;
    end
  end

  int gap_a = -1, gap_b = -1;

  task automatic chk_unit(input string tag, input int d, input int ph,
                          input logic s, input logic lo, input logic hi);
    int lo_at, hi_at;
    lo_at = d / 4;
    hi_at = d / 2 + (d + 1) / 4;
    chk(s  === (ph >= d / 2), {"R2 level ", tag}, int'(s),  int'(ph >= d / 2));
    chk(lo === (ph == lo_at), {"R3 mid-low ", tag}, int'(lo), int'(ph == lo_at));
    chk(hi === (ph == hi_at), {"R4 mid-high ", tag}, int'(hi), int'(ph == hi_at));
    chk(!(lo && hi), {"R5 overlap ", tag}, int'(lo && hi), 0);
    if (!run_seen)
      chk(!s && !lo && !hi, {"R7 idle ", tag}, int'({s, lo, hi}), 0);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk({scl_a, lo_a, hi_a, scl_b, lo_b, hi_b} === 6'b0, "R6 reset outputs",
          int'({scl_a, lo_a, hi_a, scl_b, lo_b, hi_b}), 0);
      gap_a = -1; gap_b = -1;
    end else begin
      chk_unit("A", DA, ph_a, scl_a, lo_a, hi_a);
      chk_unit("B", DB, ph_b, scl_b, lo_b, hi_b);
      // R1: spacing of mid-low pulses under continuous run.
      if (!run_seen) begin gap_a = -1; gap_b = -1; end
      else begin
        if (gap_a >= 0) gap_a++;
        if (gap_b >= 0) gap_b++;
        if (lo_a) begin
          if (gap_a >= 0) chk(gap_a == DA, "R1 period A", gap_a, DA);
          gap_a = 0;
        end
        if (lo_b) begin
          if (gap_b >= 0) chk(gap_b == DB, "R1 period B", gap_b, DB);
          gap_b = 0;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : stim
    step(3);
    rst_n = 1'b1;
    step(2);
    run = 1'b1;               // R7 restart from count 0
    step(45);
    // Drop run at every phase offset of the longer period.
    for (int off = 0; off < DA; off++) begin
      run = 1'b0;
      step(2);
      run = 1'b1;
      step(off + DA + 3);
    end
    // R6: reset in the middle of a period.
    step(4);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3 * DA * DB);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule